// File: doc/BRIEF.md
# Accumulate-Mode Final Padding Detector

This block sits beside a hash core that runs in accumulate mode, where one message reaches the core as a series of request chunks. For each chunk it decides from the chunk's own bytes whether the chunk carries the closing message padding. No "last" flag takes part in that decision, and a last-entry marker on a descriptor does not count as one.

The block keeps a running byte total across chunks, and each accepted chunk's length is added to it before any test. The trailing eight bytes of the chunk are read as a big-endian bit count, and that count divided by eight gives the message length in bytes. The padding size is the running total minus the message length. The chunk is final when three things hold: the message length does not exceed the total, the padding size is non-zero and fits inside the chunk, and the byte where the payload ends holds the marker value 0x80.

For a final chunk the block reports that end offset as the forward length, so the padding is not hashed a second time, raises the final flag and clears the total. Any other chunk forwards its whole length. The block reaches chunk bytes through a small byte-read port whose data comes back one cycle after the request.

Top module: `acc_pad_detect`

## Requirements
- R1: After reset `done_o`, `final_o`, `busy_o` and `rd_en_o` are low, and the running byte total is zero.
- R2: When a request is accepted in the idle state, its length is added to the running total before that chunk is evaluated, so an earlier chunk's length, short chunks included, moves where a later chunk's payload end is computed.
- R3: The count field is the 8 bytes at chunk offsets len-8 to len-1. Offset len-8 is the most significant byte. The message length in bytes is this 64-bit value shifted right by three.
- R4: A chunk whose message length is greater than the running total is not final.
- R5: A chunk whose padding size (running total minus message length) is zero, or larger than the chunk length, is not final.
- R6: When R4 and R5 allow it, the byte at offset len minus padding size is read, and the chunk is final only when that byte equals 0x80.
- R7: On a final chunk `done_o` pulses with `final_o` high and `fwd_len_o` equal to the payload end offset, which is always below the chunk length.
- R8: On a non-final chunk `done_o` pulses with `final_o` low and `fwd_len_o` equal to the full chunk length.
- R9: The running total returns to zero after a final chunk is reported, and is kept after a non-final one.
- R10: A chunk shorter than 8 bytes issues no reads and is reported non-final with its full length. Its length still counts toward the total.
- R11: The read port issues 8 count reads per chunk, plus one marker read only when R4 and R5 allow it. Every read address is an offset below the chunk length, and data is taken on the cycle after `rd_en_o`.
- R12: `done_o` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | New chunk request, taken only while idle |
| req_len_i | input | LEN_W | Byte length of the requested chunk |
| rd_en_o | output | 1 | Byte read request |
| rd_addr_o | output | LEN_W | Chunk-relative byte offset to read |
| rd_data_i | input | 8 | Read byte, valid the cycle after `rd_en_o` |
| busy_o | output | 1 | A chunk is being evaluated |
| done_o | output | 1 | One-cycle result strobe |
| final_o | output | 1 | Last result was a final chunk |
| fwd_len_o | output | LEN_W | Number of chunk bytes to hand to the hash core |

## Verification
The assertions check on every cycle that reads stay inside the chunk, that short chunks never start fetching, that the result strobe is a single pulse, and that the forward length relates to the chunk length as the final flag demands. They also check that a final report leaves the total at zero. Whether a given chunk is correctly judged final depends on the bytes, the big-endian field order and the accumulated total over earlier chunks. Only the bench's directed chunk sequences show this, including the marker mismatch, the zero and oversize padding cases, and a short chunk moving a later payload end.

// File: rtl/apd_pkg.sv
package apd_pkg;

   localparam logic [7:0] PAD_MARKER = 8'h80;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DRAIN,
      ST_JUDGE,
      ST_MARK,
      ST_REPORT
   } apd_state_e;

endpackage

// File: rtl/apd_total.sv
module apd_total #(
   parameter int LEN_W = 28,
   parameter int TOT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [LEN_W-1:0] add_len,
   input  logic             clr,
   output logic [TOT_W-1:0] total
);

   logic [TOT_W-1:0] total_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total_q <= '0;
      end else if (clr) begin
         total_q <= '0;
      end else if (add_en) begin
         total_q <= total_q + TOT_W'(add_len);
      end
   end

   assign total = total_q;

endmodule

// File: rtl/apd_gather.sv
module apd_gather #(
   parameter int CNT_W = 64,
   localparam int NB    = CNT_W / 8,
   localparam int IDX_W = $clog2(NB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [IDX_W-1:0] cap_idx,
   input  logic [7:0]       byte_in,
   output logic [CNT_W-1:0] count
);

   // Lane k holds the byte read from offset len-NB+k; lane 0 is most significant.
   for (genvar k = 0; k < NB; k++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (cap && (cap_idx == IDX_W'(k))) begin
            lane_q <= byte_in;
         end
      end
      assign count[CNT_W-1-8*k -: 8] = lane_q;
   end

endmodule

// File: rtl/apd_judge.sv
module apd_judge #(
   parameter int LEN_W = 28,
   parameter int TOT_W = 32,
   parameter int CNT_W = 64
) (
   input  logic [CNT_W-1:0] count,
   input  logic [TOT_W-1:0] total,
   input  logic [LEN_W-1:0] len,
   output logic             cand_ok,
   output logic [LEN_W-1:0] offset
);

   logic [CNT_W-1:0] msg_len;
   logic [TOT_W-1:0] pad;
   logic             len_fits;
   logic             pad_fits;

   always_comb begin
      msg_len  = count >> 3;
      len_fits = msg_len <= CNT_W'(total);
      pad      = total - msg_len[TOT_W-1:0];
      pad_fits = (pad != '0) && (pad <= TOT_W'(len));
      cand_ok  = len_fits && pad_fits;
      offset   = len - pad[LEN_W-1:0];
   end

endmodule

// File: rtl/acc_pad_detect.sv
module acc_pad_detect #(
   parameter int LEN_W = 28,
   parameter int TOT_W = 32,
   parameter int CNT_W = 64,
   localparam int NB    = CNT_W / 8,
   localparam int IDX_W = $clog2(NB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [LEN_W-1:0] req_len_i,
   output logic             rd_en_o,
   output logic [LEN_W-1:0] rd_addr_o,
   input  logic [7:0]       rd_data_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             final_o,
   output logic [LEN_W-1:0] fwd_len_o
);
   import apd_pkg::*;

   if (LEN_W > TOT_W) begin : g_chk_len
      $error("LEN_W must not exceed TOT_W");
   end
   if (CNT_W <= TOT_W) begin : g_chk_cnt
      $error("CNT_W must be wider than TOT_W");
   end
   if ((CNT_W % 8) != 0 || NB < 2) begin : g_chk_bytes
      $error("CNT_W must be a multiple of 8 of at least 16");
   end

   apd_state_e       state_q;
   logic [LEN_W-1:0] len_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] cap_idx_q;
   logic             cap_q;
   logic             fin_q;
   logic [LEN_W-1:0] fwd_q;
   logic [TOT_W-1:0] total;
   logic [CNT_W-1:0] count;
   logic             cand_ok;
   logic [LEN_W-1:0] offset;
   logic             accept;
   logic             marker_hit;

   assign accept     = req_i && (state_q == ST_IDLE);
   assign marker_hit = (rd_data_i == PAD_MARKER);

   apd_total #(.LEN_W(LEN_W), .TOT_W(TOT_W)) u_total (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_en  (accept),
      .add_len (req_len_i),
      .clr     ((state_q == ST_REPORT) && fin_q),
      .total   (total)
   );

   apd_gather #(.CNT_W(CNT_W)) u_gather (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (cap_q),
      .cap_idx (cap_idx_q),
      .byte_in (rd_data_i),
      .count   (count)
   );

   apd_judge #(.LEN_W(LEN_W), .TOT_W(TOT_W), .CNT_W(CNT_W)) u_judge (
      .count   (count),
      .total   (total),
      .len     (len_q),
      .cand_ok (cand_ok),
      .offset  (offset)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         len_q     <= '0;
         idx_q     <= '0;
         cap_idx_q <= '0;
         cap_q     <= 1'b0;
         fin_q     <= 1'b0;
         fwd_q     <= '0;
      end else begin
         cap_q     <= (state_q == ST_FETCH);
         cap_idx_q <= idx_q;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  len_q <= req_len_i;
                  idx_q <= '0;
                  if (req_len_i < LEN_W'(NB)) begin
                     fin_q   <= 1'b0;
                     fwd_q   <= req_len_i;
                     state_q <= ST_REPORT;
                  end else begin
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == IDX_W'(NB - 1)) begin
                  state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: state_q <= ST_JUDGE;
            ST_JUDGE: begin
               if (cand_ok) begin
                  state_q <= ST_MARK;
               end else begin
                  fin_q   <= 1'b0;
                  fwd_q   <= len_q;
                  state_q <= ST_REPORT;
               end
            end
            ST_MARK: begin
               fin_q   <= marker_hit;
               fwd_q   <= marker_hit ? offset : len_q;
               state_q <= ST_REPORT;
            end
            ST_REPORT: state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_en_o   = 1'b0;
      rd_addr_o = '0;
      if (state_q == ST_FETCH) begin
         rd_en_o   = 1'b1;
         rd_addr_o = len_q - LEN_W'(NB) + LEN_W'(idx_q);
      end else if ((state_q == ST_JUDGE) && cand_ok) begin
         rd_en_o   = 1'b1;
         rd_addr_o = offset;
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_REPORT);
   assign final_o   = fin_q;
   assign fwd_len_o = fwd_q;

   AST_RD_IN_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> (rd_addr_o < len_q)); // R11
   AST_SHORT_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH) |-> (len_q >= LEN_W'(NB))); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R12
   AST_NONFINAL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !final_o) |-> (fwd_len_o == len_q)); // R8
   AST_FINAL_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && final_o) |-> (fwd_len_o < len_q)); // R7
   AST_TOTAL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && final_o) |=> (total == '0)); // R9

endmodule

// File: tb/acc_pad_detect_bench.sv
module acc_pad_detect_bench;

   localparam int LEN_W = 28;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req = 1'b0;
   logic [LEN_W-1:0] req_len = '0;
   logic             rd_en;
   logic [LEN_W-1:0] rd_addr;
   logic [7:0]       rd_data = 8'h00;
   logic             busy, done, fin;
   logic [LEN_W-1:0] fwd_len;
   logic [7:0]       mem [0:255];

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

   acc_pad_detect u_acc_pad_detect (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_len_i(req_len),
      .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .busy_o(busy), .done_o(done), .final_o(fin), .fwd_len_o(fwd_len)
   );

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_mem(byte v);
      for (int i = 0; i < 256; i++) mem[i] = v;
   endtask

   task automatic put_count(int len, longint bits);
      for (int k = 0; k < 8; k++) mem[len - 8 + k] = 8'(bits >> (8 * (7 - k)));
   endtask

   task automatic run_chunk(string tag, int len, bit exp_fin, int exp_fwd, int exp_reads);
      int reads = 0;
      int bad_addr = 0;
      int waited = 0;
      @(negedge clk);
      req = 1'b1;
      req_len = LEN_W'(len);
      @(negedge clk);
      req = 1'b0;
      while (!done && waited < 100) begin
         if (rd_en) begin
            reads++;
            if (rd_addr >= LEN_W'(len)) bad_addr++;
         end
         waited++;
         @(negedge clk);
      end
      chk({tag, " R12 done seen"}, done, 1);
      chk({tag, " R7/R8 final"}, fin, exp_fin);
      chk({tag, " R7/R8 fwd_len"}, fwd_len, exp_fwd);
      chk({tag, " R11 reads"}, reads, exp_reads);
      chk({tag, " R11 addr in chunk"}, bad_addr, 0);
      @(negedge clk);
      chk({tag, " R12 single pulse"}, done, 0);
   endtask

   task automatic t_reset();
      chk("R1 done", done, 0);
      chk("R1 final", fin, 0);
      chk("R1 busy", busy, 0);
      chk("R1 rd_en", rd_en, 0);
   endtask

   // R3 R7 R9: 5-byte message padded into one 64-byte chunk; total zero afterwards.
   task automatic t_single_final(string tag);
      clear_mem(8'h00);
      for (int i = 0; i < 5; i++) mem[i] = 8'(8'h31 + i);
      mem[5] = 8'h80;
      put_count(64, 40);
      run_chunk(tag, 64, 1'b1, 5, 9);
   endtask

   // R2 R4 R8 R3: oversize count rejects chunk A, chunk B ends a 60-byte message.
   task automatic t_accumulate();
      clear_mem(8'hFF);
      run_chunk("R4 oversize", 32, 1'b0, 32, 8);
      clear_mem(8'h00);
      mem[28] = 8'h80;
      put_count(64, 480);
      run_chunk("R2 accumulated", 64, 1'b1, 28, 9);
   endtask

   // R6: marker byte wrong, total then stays at 64.
   task automatic t_bad_marker();
      clear_mem(8'h00);
      mem[5] = 8'h81;
      put_count(64, 40);
      run_chunk("R6 marker", 64, 1'b0, 64, 9);
   endtask

   // R5: padding larger than chunk, then padding of zero.
   task automatic t_pad_limits();
      clear_mem(8'h00);
      run_chunk("R5 pad too big", 16, 1'b0, 16, 8);
      clear_mem(8'h00);
      mem[7] = 8'h80;
      put_count(16, 96 * 8);
      run_chunk("R5 pad zero", 16, 1'b0, 16, 8);
   endtask

   // R10 R2: short chunk counted, then final chunk whose end depends on it.
   task automatic t_short();
      clear_mem(8'h80);
      run_chunk("R10 short", 5, 1'b0, 5, 0);
      clear_mem(8'h00);
      mem[7] = 8'h80;
      put_count(16, 108 * 8);
      run_chunk("R10 after short", 16, 1'b1, 7, 9);
   endtask

   initial begin
      #3_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      clear_mem(8'h00);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_final("R3 single");
      t_accumulate();
      t_bad_marker();
      t_pad_limits();
      t_short();
      t_single_final("R9 after clear");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule